// File: doc/BRIEF.md
# Sample-Rate Switch Debouncer with Edge Flags

This block conditions five active-low user switches and one enable input of an audio processor. The switch, enable and tap pins first pass a two-flop synchronizer. They are then sampled once per audio sample period, on a one-clock strobe. No pin state is taken between strobes, so both output words stay constant for the whole sample period. The block produces two 16-bit status words. One is a raw word that carries the synchronized pin levels as they were sampled. The other is a debounced word that carries the filtered switch levels, one-sample push and release pulses for each switch, and the filtered enable level.

Each switch and the enable input has its own debounce channel. A channel is a two-state machine. In `ST_STEADY` it holds its level, and it leaves that state (transition *mismatch seen*) when a sample differs from that level. In `ST_VERIFY` it counts consecutive differing samples. It returns to `ST_STEADY` on *bounce back* when a sample matches the old level again, and on *confirm* when enough differing samples have arrived, at which point it adopts the new level. The debounce count is a configuration input and is held static while the block runs. The value 0 bypasses `ST_VERIFY` entirely (transition *direct adopt*). Push and release pulses come from comparing each debounced level with its value in the previous sample period.

Top module: `sw_debounce_top`

## Requirements
- R1: While reset is asserted and after it is released, until the first strobe, the raw word reads 0x007F and the debounced word reads 0x801F. All levels read released/high and all edge flags read 0.
- R2: At each strobe the raw word captures the synchronized pins. Switch n goes in bit n for n = 0..4, the enable pin in bit 5 and the tap pin in bit 6. Bits 7 to 15 read 0. A pressed switch reads 0.
- R3: Both words change only at a clock edge where the strobe is high. Between strobes they hold their values even if pins change.
- R4: With a debounce count N > 0, a switch's debounced level (bits 0 to 4) takes a new value at the strobe that samples that value for the (N+1)th consecutive time.
- R5: A sample equal to the current debounced level, taken before the count completes, discards the progress. A later differing sample starts a fresh run of N+1.
- R6: With a debounce count of 0, the debounced level takes a new sampled value at the same strobe at which the raw word shows it.
- R7: Push flag n (bit 10+n) is 1 for exactly one sample period, starting at the strobe where debounced level n goes from 1 to 0.
- R8: Release flag n (bit 5+n) is 1 for exactly one sample period, starting at the strobe where debounced level n goes from 0 to 1.
- R9: Bit 15 is the debounced enable level, filtered under the same rules as the switches. The tap pin is not debounced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-clock strobe, once per audio sample period |
| sw_pin_i | input | 5 | Switch pins, 0 when pressed |
| en_pin_i | input | 1 | Enable pin |
| tap_pin_i | input | 1 | Tap pin (raw level only) |
| db_reload_i | input | 8 | Debounce count in sample periods, static during operation |
| raw_word_o | output | 16 | Sampled pin levels |
| db_word_o | output | 16 | Debounced levels, release flags, push flags, enable level |

## Verification
The bench drives several patterns, each aimed at a different fault:
- Clean presses held well past the count separate a correct N+1 latency from off-by-one counting.
- A press that bounces once and then settles shows whether a matching sample really restarts the run rather than merely pausing it.
- Presses on several switches at once, overlapping with enable toggles, expose swapped bit positions between the level, release and push fields.
- A second phase under reset with a count of 0 checks direct adoption and confirms that each edge flag lasts exactly one sample period.
- Pins that change between strobes check that nothing leaks through outside a strobe.

// File: rtl/sw_db_pkg.sv
package sw_db_pkg;
    typedef enum logic {
        ST_STEADY = 1'b0,
        ST_VERIFY = 1'b1
    } db_state_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
        end
    end

    assign pin_o = stage2_q;
endmodule

// File: rtl/db_chan.sv
module db_chan
    import sw_db_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    input  logic [CW-1:0] reload,
    output logic          lvl_o
);
    db_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lvl_q, lvl_d;

    // next-state and datapath decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        if (tick) begin
            unique case (state_q)
                ST_STEADY: begin
                    if (din != lvl_q) begin
                        if (reload == '0) begin
                            lvl_d = din;               // direct adopt
                        end else begin
                            cnt_d   = reload;          // mismatch seen
                            state_d = ST_VERIFY;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (din == lvl_q) begin
                        state_d = ST_STEADY;           // bounce back
                    end else if (cnt_q == CW'(1)) begin
                        lvl_d   = din;                 // confirm
                        state_d = ST_STEADY;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                default: state_d = ST_STEADY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STEADY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            lvl_q <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lvl_q));

    p_zero_reload_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload == '0) |=> (lvl_q == $past(din)));

    p_verify_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERIFY) |-> (cnt_q != '0));
endmodule

// File: rtl/sw_edges.sv
module sw_edges #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] push_o,
    output logic [N-1:0] rel_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= '1;
        else if (tick) prev_q <= lvl_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign push_o[i] =  prev_q[i] & ~lvl_i[i];
        assign rel_o[i]  = ~prev_q[i] &  lvl_i[i];
    end

    p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (|push_o)) |=> ((push_o & $past(push_o)) == '0));

    p_release_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (|rel_o)) |=> ((rel_o & $past(rel_o)) == '0));
endmodule

// File: rtl/sw_debounce_top.sv
module sw_debounce_top #(
    parameter int NUM_SW = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic [NUM_SW-1:0] sw_pin_i,
    input  logic              en_pin_i,
    input  logic              tap_pin_i,
    input  logic [CNT_W-1:0]  db_reload_i,
    output logic [15:0]       raw_word_o,
    output logic [15:0]       db_word_o
);
    localparam int NCH    = NUM_SW + 1;
    localparam int SYNC_W = NUM_SW + 2;
    localparam int PAD_W  = 16 - SYNC_W;

    logic [SYNC_W-1:0] sync_s;
    logic [SYNC_W-1:0] raw_q;
    logic [NCH-1:0]    lvl_s;
    logic [NUM_SW-1:0] push_s;
    logic [NUM_SW-1:0] rel_s;

    sw_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({tap_pin_i, en_pin_i, sw_pin_i}),
        .pin_o (sync_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_q <= '1;
        else if (smp_tick) raw_q <= sync_s;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        db_chan #(.CW(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (smp_tick),
            .din    (sync_s[c]),
            .reload (db_reload_i),
            .lvl_o  (lvl_s[c])
        );
    end

    sw_edges #(.N(NUM_SW)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_tick),
        .lvl_i  (lvl_s[NUM_SW-1:0]),
        .push_o (push_s),
        .rel_o  (rel_s)
    );

    assign raw_word_o = {{PAD_W{1'b0}}, raw_q};
    assign db_word_o  = {lvl_s[NUM_SW], push_s, rel_s, lvl_s[NUM_SW-1:0]};

    p_raw_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(raw_word_o));

    p_db_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(db_word_o));
endmodule

// File: tb/test_sw_debounce_top.sv
module test_sw_debounce_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b0;
    logic [4:0]  sw_pin = 5'h1F;
    logic        en_pin = 1'b1;
    logic        tap_pin = 1'b1;
    logic [7:0]  reload = 8'd3;
    logic [15:0] raw_word, db_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int         m_lvl [6];
    int         m_run [6];
    int         m_prev [5];
    logic [6:0] m_raw;
    logic [15:0] keep_raw, keep_db;

    always #2.5 clk = ~clk;

    sw_debounce_top i_sw_debounce_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_tick    (smp_tick),
        .sw_pin_i    (sw_pin),
        .en_pin_i    (en_pin),
        .tap_pin_i   (tap_pin),
        .db_reload_i (reload),
        .raw_word_o  (raw_word),
        .db_word_o   (db_word)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference: a level is adopted once the differing run reaches reload+1
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_lvl[i] = 1; m_run[i] = 0; end
            for (int i = 0; i < 5; i++) m_prev[i] = 1;
            m_raw = 7'h7F;
        end else if (smp_tick) begin
            m_raw = {tap_pin, en_pin, sw_pin};
            for (int i = 0; i < 5; i++) m_prev[i] = m_lvl[i];
            for (int i = 0; i < 6; i++) begin
                int x;
                x = int'(m_raw[i]);
                if (x != m_lvl[i]) begin
                    m_run[i]++;
                    if (m_run[i] >= int'(reload) + 1) begin
                        m_lvl[i] = x;
                        m_run[i] = 0;
                    end
                end else begin
                    m_run[i] = 0;
                end
            end
        end
    end

    function automatic logic [15:0] exp_db();
        logic [15:0] w;
        w = '0;
        for (int i = 0; i < 5; i++) begin
            w[i]    = m_lvl[i][0];
            w[5+i]  = (m_prev[i] == 0) && (m_lvl[i] == 1);
            w[10+i] = (m_prev[i] == 1) && (m_lvl[i] == 0);
        end
        w[15] = m_lvl[5][0];
        return w;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] e;
            e = exp_db();
            check("R2 raw word", raw_word, {9'b0, m_raw});
            check("R4 debounced levels", {11'b0, db_word[4:0]}, {11'b0, e[4:0]});
            check("R8 release flags", {11'b0, db_word[9:5]}, {11'b0, e[9:5]});
            check("R7 push flags", {11'b0, db_word[14:10]}, {11'b0, e[14:10]});
            check("R9 enable level", {15'b0, db_word[15]}, {15'b0, e[15]});
        end
    end

    // drive one sample period: change pins, check hold (R3), then strobe
    task automatic sample(input logic [4:0] sw, input logic en, input logic tap);
        @(negedge clk);
        keep_raw = raw_word;
        keep_db  = db_word;
        sw_pin = sw; en_pin = en; tap_pin = tap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 raw hold", raw_word, keep_raw);
        check("R3 db hold", db_word, keep_db);
        smp_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 raw in reset", raw_word, 16'h007F);
        check("R1 db in reset", db_word, 16'h801F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 raw after reset", raw_word, 16'h007F);
        check("R1 db after reset", db_word, 16'h801F);

        // phase 1: count 3
        sample(5'h1F, 1, 1);
        for (int k = 0; k < 6; k++) sample(5'h1E, 1, k[0]);    // sw0 pressed
        for (int k = 0; k < 5; k++) sample(5'h1F, 1, 1);       // released
        // sw2 bounce: press 2, release 1, press 3 -> not yet
        sample(5'h1B, 1, 1); sample(5'h1B, 1, 1);
        sample(5'h1F, 1, 1);
        sample(5'h1B, 1, 1); sample(5'h1B, 1, 1); sample(5'h1B, 1, 1);
        check("R5 sw2 still released after restart", {15'b0, db_word[2]}, 16'h0001);
        sample(5'h1B, 1, 1);
        check("R5 sw2 adopts after fresh run", {15'b0, db_word[2]}, 16'h0000);
        check("R7 sw2 push flag", {15'b0, db_word[12]}, 16'h0001);
        // several switches plus enable low together
        for (int k = 0; k < 6; k++) sample(5'h05, 0, 0);
        for (int k = 0; k < 6; k++) sample(5'h1F, 1, 1);
        sample(5'h0A, 0, 1);
        for (int k = 0; k < 5; k++) sample(5'h1F, 1, 0);

        // phase 2: count 0
        @(negedge clk);
        rst_n = 1'b0;
        reload = 8'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sample(5'h1D, 1, 1);
        check("R6 sw1 follows at once", {15'b0, db_word[1]}, 16'h0000);
        check("R7 sw1 push set", {15'b0, db_word[11]}, 16'h0001);
        sample(5'h1D, 1, 1);
        check("R7 sw1 push one period", {15'b0, db_word[11]}, 16'h0000);
        sample(5'h1F, 0, 1);
        check("R8 sw1 release set", {15'b0, db_word[6]}, 16'h0001);
        check("R9 enable follows at once", {15'b0, db_word[15]}, 16'h0000);
        sample(5'h1F, 0, 1);
        check("R8 sw1 release one period", {15'b0, db_word[6]}, 16'h0000);
        for (int k = 0; k < 4; k++) sample(5'(k * 7), k[0], k[1]);
        sample(5'h1F, 1, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule